// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple 32-bit processor and works out, once per clock, where execution goes next. Four sources compete for the next value: the sequential address four bytes on, a conditional branch relative to the PC, a jump that keeps the top of the address and takes a 26-bit word address from the instruction, and an indirect jump to an address held in a register. The unit also supplies the return address and its destination register index for subroutine calls. The instruction decoder drives the one-bit request lines and the instruction fields. The register file supplies the operand and the result of the equality compare.

All PC-relative and region-relative arithmetic uses the incremented address (PC + 4). Branch offsets and jump fields count words, so they are scaled by four. When more than one request is raised in the same cycle, a fixed priority picks one.

Top module: `pc_next_unit`

## Requirements
- R1: With no request active, or with a branch whose condition fails, the PC increases by 4 on each rising clock edge, wrapping modulo 2^32.
- R2: A taken branch loads PC + 4 + (sign-extended 16-bit offset × 4). A negative offset moves the PC backward.
- R3: The branch-if-equal request is taken only when the equality input is 1.
- R4: The branch-if-not-equal request is taken only when the equality input is 0.
- R5: A jump loads {bits 31:28 of (PC + 4), 26-bit target field, 2'b00}. The top four bits come from PC + 4 even when that addition crosses into a new 256 MB region.
- R6: A jump-and-link jumps as in R5. In the same cycle as the request, linkAddr equals PC + 4, linkIdx equals 31 and linkWe is 1. In every cycle without a winning jump-and-link request, linkWe is 0.
- R7: A jump-to-register loads the PC with the 32-bit register operand, unaligned values included.
- R8: A synchronous reset loads the PC with the reset vector (default 0). The reset overrides every request.
- R9: Simultaneous requests resolve in this order: jump-to-register first, then jump or jump-and-link, then branch, then sequential. A jump-and-link that loses to jump-to-register leaves linkWe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| offsetField | input | 16 | Signed branch offset in words |
| targetField | input | 26 | Jump word address |
| regValue | input | 32 | Register operand for jump-to-register |
| regsEqual | input | 1 | 1 when the two compared registers are equal |
| reqBrEq | input | 1 | Branch-if-equal request |
| reqBrNe | input | 1 | Branch-if-not-equal request |
| reqJump | input | 1 | Jump request |
| reqJumpLink | input | 1 | Jump-and-link request |
| reqJumpReg | input | 1 | Jump-to-register request |
| pc | output | 32 | Current program counter |
| linkAddr | output | 32 | Return address (PC + 4) |
| linkIdx | output | 5 | Destination register index for the return address (31) |
| linkWe | output | 1 | Return-address write enable |

## Verification
The hardest situation to reach from the ports is a jump issued from the last word of a 256 MB region. There, PC + 4 carries into bit 28, so the region bits of the target differ from those of the current PC. Random stimulus almost never lands on such an address. The bench therefore first uses a jump-to-register to place the PC at 0x0FFFFFFC and then issues a jump, which gives a result in region 1. Random cycles that raise several requests at once, from both directions, exercise the priority order and the suppressed link write.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;
  // Selection strobes from control to datapath
  typedef struct packed {
    logic selReg;
    logic selJump;
    logic selBranch;
    logic linkWe;
  } pcSelT;
endpackage

// File: rtl/pc_next_ctrl.sv
module pc_next_ctrl
  import pc_next_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  regsEqual,
  input  logic  reqBrEq,
  input  logic  reqBrNe,
  input  logic  reqJump,
  input  logic  reqJumpLink,
  input  logic  reqJumpReg,
  output pcSelT sel
);
  logic branchTaken;
  logic anyJump;

  assign branchTaken = (reqBrEq & regsEqual) | (reqBrNe & ~regsEqual);
  assign anyJump     = reqJump | reqJumpLink;

  always_comb begin
    sel.selReg    = reqJumpReg;
    sel.selJump   = ~reqJumpReg & anyJump;
    sel.selBranch = ~reqJumpReg & ~anyJump & branchTaken;
    sel.linkWe    = reqJumpLink & ~reqJumpReg;
  end

  // R9: at most one source wins
  p_one_source_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.selReg, sel.selJump, sel.selBranch}));

  // R9: register jump masks the link write
  p_jr_masks_link_r9: assert property (@(posedge clk) disable iff (rst)
    reqJumpReg |-> !sel.linkWe);

  // R3/R4: a branch never wins when its condition fails
  p_branch_cond_r3: assert property (@(posedge clk) disable iff (rst)
    (reqBrEq && !reqBrNe && !regsEqual) |-> !sel.selBranch);
  p_branch_cond_r4: assert property (@(posedge clk) disable iff (rst)
    (reqBrNe && !reqBrEq && regsEqual) |-> !sel.selBranch);
endmodule

// File: rtl/pc_next_dp.sv
module pc_next_dp
  import pc_next_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          OFF_W     = 16,
  parameter int          TGT_W     = 26,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  pcSelT             sel,
  input  logic [OFF_W-1:0]  offsetField,
  input  logic [TGT_W-1:0]  targetField,
  input  logic [ADDR_W-1:0] regValue,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] linkAddr
);
  localparam int REGION_W = ADDR_W - TGT_W - 2;
  localparam int EXT_W    = ADDR_W - OFF_W - 2;

  logic [ADDR_W-1:0] pcQ, seqPc, branchPc, jumpPc, nextPc;

  assign seqPc    = pcQ + ADDR_W'(4);
  assign branchPc = seqPc + {{EXT_W{offsetField[OFF_W-1]}}, offsetField, 2'b00};
  assign jumpPc   = {seqPc[ADDR_W-1 -: REGION_W], targetField, 2'b00};

  always_comb begin
    nextPc = seqPc;
    if (sel.selReg)         nextPc = regValue;
    else if (sel.selJump)   nextPc = jumpPc;
    else if (sel.selBranch) nextPc = branchPc;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_VEC[ADDR_W-1:0];
    else     pcQ <= nextPc;
  end

  assign pc       = pcQ;
  assign linkAddr = seqPc;

  // R1: sequential advance
  p_seq_step_r1: assert property (@(posedge clk) disable iff (rst)
    !(sel.selReg || sel.selJump || sel.selBranch) |=> pcQ == $past(pcQ) + ADDR_W'(4));

  // R7: register jump lands on the operand
  p_reg_jump_r7: assert property (@(posedge clk) disable iff (rst)
    sel.selReg |=> pcQ == $past(regValue));

  // R5: jump keeps the region of the incremented PC and is word aligned
  p_jump_region_r5: assert property (@(posedge clk) disable iff (rst)
    sel.selJump |=> (pcQ[ADDR_W-1 -: REGION_W] == $past(linkAddr[ADDR_W-1 -: REGION_W]))
                    && (pcQ[1:0] == 2'b00));

  // R2: taken branch preserves word alignment relative to the old PC
  p_branch_align_r2: assert property (@(posedge clk) disable iff (rst)
    sel.selBranch |=> pcQ[1:0] == $past(pcQ[1:0]));
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          OFF_W     = 16,
  parameter int          TGT_W     = 26,
  parameter int          IDX_W     = 5,
  parameter int          LINK_REG  = 31,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  offsetField,
  input  logic [TGT_W-1:0]  targetField,
  input  logic [ADDR_W-1:0] regValue,
  input  logic              regsEqual,
  input  logic              reqBrEq,
  input  logic              reqBrNe,
  input  logic              reqJump,
  input  logic              reqJumpLink,
  input  logic              reqJumpReg,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] linkAddr,
  output logic [IDX_W-1:0]  linkIdx,
  output logic              linkWe
);
  pcSelT sel;

  pc_next_ctrl ctrl_i (
    .clk(clk), .rst(rst), .regsEqual(regsEqual),
    .reqBrEq(reqBrEq), .reqBrNe(reqBrNe), .reqJump(reqJump),
    .reqJumpLink(reqJumpLink), .reqJumpReg(reqJumpReg), .sel(sel)
  );

  pc_next_dp #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TGT_W(TGT_W), .RESET_VEC(RESET_VEC)
  ) dp_i (
    .clk(clk), .rst(rst), .sel(sel), .offsetField(offsetField),
    .targetField(targetField), .regValue(regValue),
    .pc(pc), .linkAddr(linkAddr)
  );

  assign linkIdx = IDX_W'(LINK_REG);
  assign linkWe  = sel.linkWe;

  // R6: link write only on a jump-and-link request
  p_link_req_r6: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> reqJumpLink);
endmodule

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] offsetField;
  logic [25:0] targetField;
  logic [31:0] regValue;
  logic        regsEqual, reqBrEq, reqBrNe, reqJump, reqJumpLink, reqJumpReg;
  logic [31:0] pc, linkAddr;
  logic [4:0]  linkIdx;
  logic        linkWe;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] modelPc;

  always #10 clk = ~clk;

  pc_next_unit dut_i (
    .clk(clk), .rst(rst), .offsetField(offsetField), .targetField(targetField),
    .regValue(regValue), .regsEqual(regsEqual), .reqBrEq(reqBrEq), .reqBrNe(reqBrNe),
    .reqJump(reqJump), .reqJumpLink(reqJumpLink), .reqJumpReg(reqJumpReg),
    .pc(pc), .linkAddr(linkAddr), .linkIdx(linkIdx), .linkWe(linkWe)
  );

  function automatic logic [31:0] expNext(input logic [31:0] cur);
    logic [31:0] inc;
    inc = cur + 32'd4;
    if (reqJumpReg) return regValue;
    if (reqJump || reqJumpLink) return {inc[31:28], targetField, 2'b00};
    if ((reqBrEq && regsEqual) || (reqBrNe && !regsEqual))
      return inc + {{14{offsetField[15]}}, offsetField, 2'b00};
    return inc;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] off, input logic [25:0] tgt, input logic [31:0] rv,
                       input logic eq, input logic be, input logic bn, input logic j,
                       input logic jl, input logic jr);
    offsetField = off; targetField = tgt; regValue = rv; regsEqual = eq;
    reqBrEq = be; reqBrNe = bn; reqJump = j; reqJumpLink = jl; reqJumpReg = jr;
  endtask

  // Called at a negedge with inputs set; checks link outputs, clocks once, checks pc
  task automatic stepCheck(input string tag);
    logic expWe;
    #1;
    expWe = reqJumpLink && !reqJumpReg;
    check({tag, " R6 linkWe"}, {31'd0, linkWe}, {31'd0, expWe});
    if (expWe) begin
      check("R6 linkAddr", linkAddr, modelPc + 32'd4);
      check("R6 linkIdx", {27'd0, linkIdx}, 32'd31);
    end
    modelPc = expNext(modelPc);
    @(negedge clk);
    check(tag, pc, modelPc);
  endtask

  initial begin
    #(20 * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst = 1'b1;
    drive(16'h0, 26'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R8 reset vector", pc, 32'h0);
    rst = 1'b0;
    modelPc = 32'h0;

    stepCheck("R1 sequential");
    stepCheck("R1 sequential");
    drive(16'h0, 26'h0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    stepCheck("R7 jump register");
    drive(16'hFFFE, 26'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    stepCheck("R2 R3 beq taken backward");
    drive(16'h0010, 26'h0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    stepCheck("R3 beq not taken");
    drive(16'h0020, 26'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    stepCheck("R2 R4 bne taken");
    drive(16'h0020, 26'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    stepCheck("R4 bne not taken");
    drive(16'h0, 26'h0, 32'h0FFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    stepCheck("R7 jump register to region end");
    drive(16'h0, 26'h012_3456, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    stepCheck("R5 jump crossing region");
    check("R5 region bits", {28'd0, pc[31:28]}, 32'd1);
    drive(16'h0, 26'h3FF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    stepCheck("R6 jump and link");
    drive(16'h0004, 26'h000_0100, 32'h8000_0003, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    stepCheck("R9 register jump wins");
    drive(16'h0004, 26'h000_0200, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    stepCheck("R9 jump beats branch");
    drive(16'h0, 26'h0, 32'hFFFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    stepCheck("R7 jump register to top");
    drive(16'h0, 26'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    stepCheck("R1 wrap to zero");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      drive(16'($urandom), 26'($urandom), $urandom, 1'($urandom),
            r[0] & r[1], r[2] & r[3], r[4] & r[5] & r[6], r[5] & r[7], (r == 8'hFF) | (r[7:5] == 3'b101));
      stepCheck("R9 random mix");
    end

    drive(16'h0, 26'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset overrides jump", pc, 32'h0);
    rst = 1'b0;
    modelPc = 32'h0;
    drive(16'h0, 26'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    stepCheck("R1 after reset");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule